// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block sits behind a three-colour sampling front end. It accepts one pixel per clock, carrying red, green and blue samples, and spreads the stream over two output ports per colour, A and B. The outputs can be one full-rate port, or two half-rate ports that update together (parallel) or one after the other (interleaved). It also produces a data strobe that marks each complete output set, and a line-start marker delayed to match the data.

A configuration byte carries three control bits. The block captures them only on the line-start pulse, so every line runs with one fixed routing. The alternation between ports restarts on every line, and a swap bit selects which port takes the first pixel. In parallel mode a line with an odd pixel count leaves one pixel unpaired. That pixel is pushed out when the next line starts.

Top module: `pixel_port_demux`

## Requirements
- R1: With configuration bit 7 at 0 (single port), every accepted pixel is written to port A with a one-cycle strobe. After a line start, oe_a is 1 and oe_b is 0.
- R2: With bit 7 at 1 (dual port), both enables are 1 after the line start. Accepted pixels alternate between the two ports, and the alternation restarts at slot "first" on every line start.
- R3: In dual mode with bit 6 at 1 (parallel), the first pixel of each pair is held back. On the second pixel both ports change in the same cycle, with a one-cycle strobe.
- R4: In dual mode with bit 6 at 0 (interleaved), each accepted pixel updates exactly one port. The strobe pulses on the second pixel of each pair.
- R5: With bit 5 at 1 (swap), the first pixel of each pair goes to port B and the second to port A. With bit 5 at 0, the first goes to A.
- R6: In dual mode the strobe never pulses in two consecutive cycles, so it runs at most at half the pixel rate.
- R7: Data, enables, strobe and the line-start output all appear PIPE_STAGES+1 clock edges after the inputs are sampled. The line-start output is a one-cycle pulse aligned with that latency.
- R8: The configuration byte is captured only in a line-start cycle. A change in mid-line has no effect until the next line start.
- R9: If a parallel-mode line ends with an unpaired pixel, the next line start writes that pixel to its port using the old swap setting. The other port keeps its value, and the strobe pulses in the line-start output cycle.
- R10: A pixel marked valid in the same cycle as a line start is discarded.
- R11: Reset drives both ports to zero, both enables low, and strobe and line-start output low. Pixels that arrive before the first line start after reset are discarded.
- R12: Cycles with pix_valid low produce no strobe, change no port and do not advance the alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | A pixel is present on pix_in |
| hsync_in | input | 1 | One-cycle line-start pulse |
| cfg_byte | input | 8 | Control byte: bit 7 dual, bit 6 parallel, bit 5 swap |
| pix_in | input | N_CH*W | Pixel samples, red in the top W bits, blue in the bottom W bits |
| port_a | output | N_CH*W | Port A data, same channel layout |
| port_b | output | N_CH*W | Port B data, same channel layout |
| oe_a | output | 1 | Port A drive enable |
| oe_b | output | 1 | Port B drive enable (low means high impedance) |
| data_strobe | output | 1 | One-cycle pulse marking a complete output set |
| hsync_out | output | 1 | Line-start pulse delayed to match the data |

## Verification
The bench keeps the sample width at 8 bits and the channel count at 3, and raises PIPE_STAGES to 2. The generated delay chain is therefore more than one register deep, and the latency checks land three edges after the drive. Every colour lane carries the same byte, so a single expected value covers all three lanes. A lane that is routed or held wrongly still shows as a mismatch on the full port. The vector table steps through every mode combination on successive lines. It includes odd-length parallel lines with and without swap, mid-line configuration changes, and pixels that fall in line-start cycles.

// File: rtl/pixdemux_pkg.sv
// Package: shared types and the control-byte decode for the pixel port demultiplexer.
// Assumes the control bits sit at fixed positions of one configuration byte.
package pixdemux_pkg;

    localparam int CFG_DUAL_BIT = 7;
    localparam int CFG_PAR_BIT  = 6;
    localparam int CFG_SWAP_BIT = 5;

    typedef struct packed {
        logic dual;   // 1: two ports, 0: port A only
        logic par;    // 1: pairs presented together, 0: ports update in turn
        logic swap;   // 1: first pixel of a pair goes to port B
    } route_cfg_t;

    function automatic route_cfg_t decode_cfg(input logic [7:0] raw);
        route_cfg_t c;
        c.dual = raw[CFG_DUAL_BIT];
        c.par  = raw[CFG_PAR_BIT];
        c.swap = raw[CFG_SWAP_BIT];
        return c;
    endfunction

endpackage

// File: rtl/pixdemux_delay.sv
// Module: fixed-depth register delay line for a bus of signals.
// Assumes STAGES >= 0; zero stages gives a straight wire. All stages reset to zero.
module pixdemux_delay #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 0) begin : g_wire
            assign q = d;
        end else begin : g_pipe
            logic [WIDTH-1:0] stg [STAGES];
            for (genvar s = 0; s < STAGES; s++) begin : g_stg
                if (s == 0) begin : g_head
                    // First stage: capture the raw input
                    always_ff @(posedge clk) begin
                        if (!rst_n) stg[s] <= '0;
                        else        stg[s] <= d;
                    end
                end else begin : g_body
                    // Later stages: shift from the previous stage
                    always_ff @(posedge clk) begin
                        if (!rst_n) stg[s] <= '0;
                        else        stg[s] <= stg[s-1];
                    end
                end
            end
            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pixdemux_line_ctrl.sv
// Module: per-line control. Latches routing configuration at each line start,
// tracks the pair slot (first/second) of the next pixel and qualifies pixels.
// Assumes line_start is a single-cycle pulse; pixels in that cycle are dropped.
module pixdemux_line_ctrl
    import pixdemux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    input  logic       pix_vld,
    input  logic [7:0] cfg_raw,
    output route_cfg_t cur_cfg,
    output route_cfg_t next_cfg,
    output logic       slot_second,
    output logic       pix_take
);

    logic line_open;

    // Decode the incoming byte for use at a line start
    assign next_cfg = decode_cfg(cfg_raw);

    // Accept pixels only inside a line and never in a line-start cycle
    assign pix_take = pix_vld && line_open && !line_start;

    // Hold the active configuration and the line-open flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cfg   <= '0;
            line_open <= 1'b0;
        end else if (line_start) begin
            cur_cfg   <= next_cfg;
            line_open <= 1'b1;
        end
    end

    // Pair slot pointer: cleared at each line start, flips per accepted pixel
    always_ff @(posedge clk) begin
        if (!rst_n)          slot_second <= 1'b0;
        else if (line_start) slot_second <= 1'b0;
        else if (pix_take)   slot_second <= !slot_second;
    end

endmodule

// File: rtl/pixdemux_router.sv
// Module: output stage. Routes each accepted pixel to port A or B, holds the
// first pixel of a parallel pair, flushes an unpaired pixel at line start and
// registers enables, strobe and the delayed line-start marker.
// Assumes cur_cfg is the configuration of the line now in progress.
module pixdemux_router
    import pixdemux_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          pix_take,
    input  logic          slot_second,
    input  route_cfg_t    cur_cfg,
    input  route_cfg_t    next_cfg,
    input  logic [DW-1:0] pix,
    output logic [DW-1:0] port_a,
    output logic [DW-1:0] port_b,
    output logic          oe_a,
    output logic          oe_b,
    output logic          strobe,
    output logic          line_out
);

    logic [DW-1:0] held_pix;
    logic          held_full;

    // Decoded actions for this cycle
    logic          do_flush, do_single, do_ilv, do_hold, do_pair;
    logic          wr_a, wr_b, nxt_strobe;
    logic [DW-1:0] nxt_a, nxt_b;

    // Classify the current cycle into one routing action
    always_comb begin
        do_flush  = line_start && held_full;
        do_single = pix_take && !cur_cfg.dual;
        do_ilv    = pix_take && cur_cfg.dual && !cur_cfg.par;
        do_hold   = pix_take && cur_cfg.dual && cur_cfg.par && !slot_second;
        do_pair   = pix_take && cur_cfg.dual && cur_cfg.par && slot_second;
    end

    // Work out which ports are written, with what, and whether to strobe
    always_comb begin
        wr_a       = 1'b0;
        wr_b       = 1'b0;
        nxt_a      = pix;
        nxt_b      = pix;
        nxt_strobe = 1'b0;
        if (do_flush) begin
            wr_a       = !cur_cfg.swap;
            wr_b       = cur_cfg.swap;
            nxt_a      = held_pix;
            nxt_b      = held_pix;
            nxt_strobe = 1'b1;
        end else if (do_single) begin
            wr_a       = 1'b1;
            nxt_strobe = 1'b1;
        end else if (do_ilv) begin
            wr_b       = slot_second ^ cur_cfg.swap;
            wr_a       = !(slot_second ^ cur_cfg.swap);
            nxt_strobe = slot_second;
        end else if (do_pair) begin
            wr_a       = 1'b1;
            wr_b       = 1'b1;
            nxt_a      = cur_cfg.swap ? pix : held_pix;
            nxt_b      = cur_cfg.swap ? held_pix : pix;
            nxt_strobe = 1'b1;
        end
    end

    // Holding register for the first pixel of a parallel pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_pix  <= '0;
            held_full <= 1'b0;
        end else if (do_hold) begin
            held_pix  <= pix;
            held_full <= 1'b1;
        end else if (do_flush || do_pair) begin
            held_full <= 1'b0;
        end
    end

    // Port data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_a <= '0;
            port_b <= '0;
        end else begin
            if (wr_a) port_a <= nxt_a;
            if (wr_b) port_b <= nxt_b;
        end
    end

    // Port enables follow the configuration taken at each line start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_a <= 1'b0;
            oe_b <= 1'b0;
        end else if (line_start) begin
            oe_a <= 1'b1;
            oe_b <= next_cfg.dual;
        end
    end

    // Strobe and delayed line marker share the data's register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe   <= 1'b0;
            line_out <= 1'b0;
        end else begin
            strobe   <= nxt_strobe;
            line_out <= line_start;
        end
    end

endmodule

// File: rtl/pixel_port_demux.sv
// Module: top level of the dual-port pixel output demultiplexer.
// Delays all inputs by PIPE_STAGES registers, then applies per-line control and
// routing so data, strobe and line marker share one fixed latency.
// Assumes hsync_in is a single-cycle pulse and cfg_byte is stable around it.
module pixel_port_demux
    import pixdemux_pkg::*;
#(
    parameter int W           = 8,
    parameter int N_CH        = 3,
    parameter int PIPE_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              hsync_in,
    input  logic [7:0]        cfg_byte,
    input  logic [N_CH*W-1:0] pix_in,
    output logic [N_CH*W-1:0] port_a,
    output logic [N_CH*W-1:0] port_b,
    output logic              oe_a,
    output logic              oe_b,
    output logic              data_strobe,
    output logic              hsync_out
);

    localparam int DW = N_CH * W;
    localparam int BW = DW + 8 + 2;

    logic [BW-1:0] in_bus, dly_bus;
    logic          d_hs, d_vld;
    logic [7:0]    d_cfg;
    logic [DW-1:0] d_pix;

    route_cfg_t cur_cfg, next_cfg;
    logic       slot_second, pix_take;

    // Bundle all inputs so they travel one common delay line
    assign in_bus = {hsync_in, pix_valid, cfg_byte, pix_in};
    assign {d_hs, d_vld, d_cfg, d_pix} = dly_bus;

    pixdemux_delay #(
        .WIDTH  (BW),
        .STAGES (PIPE_STAGES)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (in_bus),
        .q     (dly_bus)
    );

    pixdemux_line_ctrl u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (d_hs),
        .pix_vld     (d_vld),
        .cfg_raw     (d_cfg),
        .cur_cfg     (cur_cfg),
        .next_cfg    (next_cfg),
        .slot_second (slot_second),
        .pix_take    (pix_take)
    );

    pixdemux_router #(
        .DW (DW)
    ) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (d_hs),
        .pix_take    (pix_take),
        .slot_second (slot_second),
        .cur_cfg     (cur_cfg),
        .next_cfg    (next_cfg),
        .pix         (d_pix),
        .port_a      (port_a),
        .port_b      (port_b),
        .oe_a        (oe_a),
        .oe_b        (oe_b),
        .strobe      (data_strobe),
        .line_out    (hsync_out)
    );

endmodule

// File: rtl/pixel_port_demux_checker.sv
// Module: property checker for pixel_port_demux, attached by bind.
// Assumes synchronous active-low reset shared with the design.
module pixel_port_demux_checker #(
    parameter int DW          = 24,
    parameter int PIPE_STAGES = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hsync_in,
    input logic [DW-1:0] port_a,
    input logic [DW-1:0] port_b,
    input logic          oe_a,
    input logic          oe_b,
    input logic          data_strobe,
    input logic          hsync_out
);

    localparam int DEPTH = PIPE_STAGES + 1;

    logic [DEPTH-1:0] hs_trail;
    logic             rst_seen = 1'b0;

    // Reference delay of the line-start input, for the latency check
    always_ff @(posedge clk) begin
        if (!rst_n) hs_trail <= '0;
        else        hs_trail <= (hs_trail << 1) | DEPTH'(hsync_in);
    end

    // Remember that reset was applied at the previous edge
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R11: outputs are cleared one edge after reset is applied
    always @(negedge clk) begin
        if (rst_seen) begin
            assert_reset_clear_R11: assert (!oe_a && !oe_b && !data_strobe && !hsync_out
                                            && port_a == '0 && port_b == '0);
        end
    end

    // R7: line marker output trails the input by the fixed latency
    assert_hs_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_out == hs_trail[DEPTH-1]);

    // R1: port B is never enabled without port A
    assert_oe_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        oe_b |-> oe_a);

    // R6: in dual mode a strobe is never followed by another strobe
    assert_dual_strobe_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe && oe_b) |=> !data_strobe);

    // R3: whenever both ports change together, a strobe marks the pair
    assert_pair_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(port_a) && !$stable(port_b)) |-> data_strobe);

endmodule

bind pixel_port_demux pixel_port_demux_checker #(
    .DW          (N_CH * W),
    .PIPE_STAGES (PIPE_STAGES)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_in    (hsync_in),
    .port_a      (port_a),
    .port_b      (port_b),
    .oe_a        (oe_a),
    .oe_b        (oe_b),
    .data_strobe (data_strobe),
    .hsync_out   (hsync_out)
);

// File: tb/pixel_port_demux_bench.sv
// Bench: vector table walked by one loop, then directed reset and latency tests.
module pixel_port_demux_bench;

    localparam int W    = 8;
    localparam int N_CH = 3;
    localparam int PIPE = 2;
    localparam int LAT  = PIPE + 1;
    localparam int DW   = W * N_CH;
    localparam int NV   = 33;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pix_valid;
    logic          hsync_in;
    logic [7:0]    cfg_byte;
    logic [DW-1:0] pix_in;
    logic [DW-1:0] port_a, port_b;
    logic          oe_a, oe_b, data_strobe, hsync_out;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = !clk;

    pixel_port_demux #(
        .W           (W),
        .N_CH        (N_CH),
        .PIPE_STAGES (PIPE)
    ) u_pixel_port_demux (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid   (pix_valid),
        .hsync_in    (hsync_in),
        .cfg_byte    (cfg_byte),
        .pix_in      (pix_in),
        .port_a      (port_a),
        .port_b      (port_b),
        .oe_a        (oe_a),
        .oe_b        (oe_b),
        .data_strobe (data_strobe),
        .hsync_out   (hsync_out)
    );

    // Row: hs, vld, cfg{dual,par,swap}, pix | exp a, exp b, {oe_a, oe_b, strobe, hs_out}
    localparam logic [32:0] VEC [NV] = '{
        {1'b1,1'b0,3'b000,8'h00, 8'h00,8'h00,4'b1001}, // 0  R1 single line start
        {1'b0,1'b1,3'b000,8'h11, 8'h11,8'h00,4'b1010}, // 1  R1
        {1'b0,1'b1,3'b000,8'h12, 8'h12,8'h00,4'b1010}, // 2  R1
        {1'b0,1'b0,3'b000,8'h00, 8'h12,8'h00,4'b1000}, // 3  R12 gap
        {1'b0,1'b1,3'b000,8'h13, 8'h13,8'h00,4'b1010}, // 4  R1
        {1'b1,1'b1,3'b100,8'hAA, 8'h13,8'h00,4'b1101}, // 5  R10 pixel in line-start cycle dropped
        {1'b0,1'b1,3'b000,8'h21, 8'h21,8'h00,4'b1100}, // 6  R8 mid-line cfg ignored
        {1'b0,1'b1,3'b000,8'h22, 8'h21,8'h22,4'b1110}, // 7  R4
        {1'b0,1'b1,3'b000,8'h23, 8'h23,8'h22,4'b1100}, // 8  R4
        {1'b0,1'b0,3'b000,8'h00, 8'h23,8'h22,4'b1100}, // 9  R12 gap keeps slot
        {1'b0,1'b1,3'b000,8'h24, 8'h23,8'h24,4'b1110}, // 10 R6
        {1'b1,1'b0,3'b110,8'h00, 8'h23,8'h24,4'b1101}, // 11 R2
        {1'b0,1'b1,3'b110,8'h31, 8'h23,8'h24,4'b1100}, // 12 R3 held
        {1'b0,1'b1,3'b110,8'h32, 8'h31,8'h32,4'b1110}, // 13 R3 pair
        {1'b0,1'b1,3'b110,8'h33, 8'h31,8'h32,4'b1100}, // 14 R3
        {1'b0,1'b1,3'b110,8'h34, 8'h33,8'h34,4'b1110}, // 15 R3
        {1'b0,1'b1,3'b110,8'h35, 8'h33,8'h34,4'b1100}, // 16 R3 unpaired
        {1'b1,1'b0,3'b111,8'h00, 8'h35,8'h34,4'b1111}, // 17 R9 flush to A
        {1'b0,1'b1,3'b111,8'h41, 8'h35,8'h34,4'b1100}, // 18 R5
        {1'b0,1'b1,3'b111,8'h42, 8'h42,8'h41,4'b1110}, // 19 R5 swapped pair
        {1'b1,1'b0,3'b101,8'h00, 8'h42,8'h41,4'b1101}, // 20 R5
        {1'b0,1'b1,3'b101,8'h51, 8'h42,8'h51,4'b1100}, // 21 R5 first to B
        {1'b0,1'b1,3'b101,8'h52, 8'h52,8'h51,4'b1110}, // 22 R4
        {1'b0,1'b1,3'b101,8'h53, 8'h52,8'h53,4'b1100}, // 23 R5
        {1'b1,1'b0,3'b000,8'h00, 8'h52,8'h53,4'b1001}, // 24 R1
        {1'b0,1'b1,3'b000,8'h61, 8'h61,8'h53,4'b1010}, // 25 R1
        {1'b0,1'b1,3'b111,8'h62, 8'h62,8'h53,4'b1010}, // 26 R8
        {1'b1,1'b0,3'b111,8'h00, 8'h62,8'h53,4'b1101}, // 27 R2
        {1'b0,1'b1,3'b111,8'h71, 8'h62,8'h53,4'b1100}, // 28 R3
        {1'b0,1'b1,3'b111,8'h72, 8'h72,8'h71,4'b1110}, // 29 R5
        {1'b0,1'b1,3'b111,8'h73, 8'h72,8'h71,4'b1100}, // 30 R3
        {1'b1,1'b0,3'b000,8'h00, 8'h72,8'h73,4'b1011}, // 31 R9 flush to B
        {1'b0,1'b1,3'b000,8'h81, 8'h81,8'h73,4'b1010}  // 32 R1
    };

    localparam int REQ [NV] = '{1,1,1,12,1,10,8,4,4,12,6,2,3,3,3,3,3,9,5,5,5,5,4,5,1,1,8,2,3,5,3,9,1};

    task automatic check_out(input string tag, input logic [7:0] ea, input logic [7:0] eb,
                             input logic [3:0] ctl);
        n_chk++;
        if (port_a !== {N_CH{ea}} || port_b !== {N_CH{eb}} ||
            {oe_a, oe_b, data_strobe, hsync_out} !== ctl) begin
            n_bad++;
            $display("FAIL %s: got a=%h b=%h oe/stb/hs=%b expected a=%h b=%h oe/stb/hs=%b",
                     tag, port_a, port_b, {oe_a, oe_b, data_strobe, hsync_out},
                     {N_CH{ea}}, {N_CH{eb}}, ctl);
        end
    endtask

    task automatic drive(input logic hs, input logic vld, input logic [2:0] c, input logic [7:0] p);
        hsync_in  = hs;
        pix_valid = vld;
        cfg_byte  = {c, 5'b00000};
        pix_in    = {N_CH{p}};
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 3'b000, 8'h00);
        repeat (3) @(negedge clk);
        // R11: reset state
        check_out("R11 reset", 8'h00, 8'h00, 4'b0000);
        rst_n = 1'b1;

        // R11: a pixel before the first line start is dropped
        drive(1'b0, 1'b1, 3'b100, 8'h99);
        @(negedge clk);
        drive(1'b0, 1'b0, 3'b000, 8'h00);
        repeat (LAT) @(negedge clk);
        check_out("R11 pre-line pixel", 8'h00, 8'h00, 4'b0000);

        // Table walk
        for (int i = 0; i < NV + LAT; i++) begin
            @(negedge clk);
            if (i >= LAT)
                check_out($sformatf("R%0d row %0d", REQ[i-LAT], i-LAT),
                          VEC[i-LAT][19:12], VEC[i-LAT][11:4], VEC[i-LAT][3:0]);
            if (i < NV) drive(VEC[i][32], VEC[i][31], VEC[i][30:28], VEC[i][27:20]);
            else        drive(1'b0, 1'b0, 3'b000, 8'h00);
        end

        // R7: exact latency of line marker and data (single mode, port A holds 81)
        @(negedge clk);
        drive(1'b1, 1'b0, 3'b000, 8'h00);
        @(negedge clk);
        drive(1'b0, 1'b1, 3'b000, 8'h5A);
        @(negedge clk);
        drive(1'b0, 1'b0, 3'b000, 8'h00);
        repeat (LAT - 2) @(negedge clk);
        check_out("R7 one edge early", 8'h81, 8'h73, 4'b1001);
        @(negedge clk);
        check_out("R7 data at latency", 8'h5A, 8'h73, 4'b1010);
        @(negedge clk);
        check_out("R7 strobe one cycle", 8'h5A, 8'h73, 4'b1000);

        // R11: reset in mid-operation clears everything
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_out("R11 mid-run reset", 8'h00, 8'h00, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule